// File: doc/BRIEF.md
# Conversion Result Readout Formatter

This block stands between a converter's result holding stage and a byte-wide serial shifter. When a read begins, it takes a copy of the current converter result and its status byte. If clamping is enabled and the result is flagged out of range, the copy is saturated to all ones or all zeros. The block then feeds the bytes of the read to the shifter one at a time, using a load strobe to offer each byte and a byte-done handshake to request the next.

A read carries the status byte only, the result only, or the status byte followed by the result. The choice depends on the register selected, on a chaining setting and on a streaming setting. The result is sent as three bytes in full width and as two bytes in narrow width, most significant byte first. Narrow width keeps the top sixteen bits of the internal result without rounding.

Top module: `rdfmt_top`

## Requirements
- R1: After reset, and whenever no read is in progress, `xfer_busy`, `byte_load` and `xfer_last` are 0 and `byte_out` is 0.
- R2: With `wide_sel`=1, the result part of a read is three bytes, `res[23:16]`, then `res[15:8]`, then `res[7:0]`.
- R3: With `wide_sel`=0, the result part is two bytes, `res[23:16]` then `res[15:8]`. The low byte is dropped without rounding.
- R4: With `clamp_en`=1 and `oor_flag`=1, the sent result is 24'hFFFFFF when `oor_high`=1 and 24'h000000 when `oor_high`=0.
- R5: With `clamp_en`=0, the sent result equals `res_in` whatever `oor_flag` and `oor_high` hold.
- R6: With `dump_en`=0 and `cont_rd`=0, `rd_sel`=0 (status register) sends only the status byte and `rd_sel`=1 (data register) sends only the result bytes.
- R7: With `dump_en`=1, every read sends the status byte first and the result bytes right after it, for either value of `rd_sel`.
- R8: With `cont_rd`=1, reads use the R7 ordering whatever `dump_en` holds.
- R9: The result, the clamp decision, the status byte and the width are captured in the cycle a read is accepted. Changes to these inputs later in the transfer do not alter the bytes sent.
- R10: Each byte is offered by a single-cycle `byte_load` pulse. The next pulse comes in the cycle after `byte_done`, and never without it. `rd_start` is ignored while a read is in progress. The transfer ends in the cycle after `byte_done` for the byte flagged by `xfer_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_in | input | 24 | Current converter result |
| oor_flag | input | 1 | Result lies outside the nominal range |
| oor_high | input | 1 | Direction of the excursion, 1 = above range |
| status_in | input | 8 | Current channel status byte |
| wide_sel | input | 1 | 1 = 24-bit result, 0 = 16-bit result |
| clamp_en | input | 1 | Saturate out-of-range results |
| dump_en | input | 1 | Chain the status and result reads |
| cont_rd | input | 1 | Streaming read mode, forces chaining |
| rd_start | input | 1 | Begin a read (accepted only when idle) |
| rd_sel | input | 1 | Addressed register: 0 = status, 1 = data |
| byte_done | input | 1 | Shifter has finished the current byte |
| byte_out | output | 8 | Byte offered to the shifter |
| byte_load | output | 1 | One-cycle strobe: load `byte_out` |
| xfer_busy | output | 1 | Read in progress |
| xfer_last | output | 1 | Current byte is the final one of the read |

## Verification
Some rules are checked by the assertions on every cycle. A load strobe appears only inside a transfer. The slot counter stays below the slot count fixed at acceptance. The held copy does not move while a read runs. A clamped capture becomes all ones or all zeros. The last byte's handshake ends the transfer. Only the bench's sweep can show that byte order, byte count and content are right for every mix of width, clamping, chaining, streaming and selected register. The bench also shows that changes to the inputs and stray start requests during a transfer do not alter the bytes sent.

// File: rtl/rdfmt_pkg.sv
package rdfmt_pkg;
  parameter int BYTE_W       = 8;
  parameter int FULL_BYTES   = 3;
  parameter int NARROW_BYTES = 2;
  localparam int FULL_W = BYTE_W * FULL_BYTES;
  localparam int CNT_W  = $clog2(FULL_BYTES + 2);

  // Saturation rule applied at capture time.
  function automatic logic [FULL_W-1:0] clamp_result(
    input logic [FULL_W-1:0] raw,
    input logic              oor,
    input logic              oor_hi,
    input logic              clamp_on
  );
    if (clamp_on && oor) return oor_hi ? {FULL_W{1'b1}} : {FULL_W{1'b0}};
    return raw;
  endfunction

  // Byte k of the MSB-first stream; identical for narrow width (top bytes).
  function automatic logic [BYTE_W-1:0] data_byte(
    input logic [FULL_W-1:0] word,
    input logic [CNT_W-1:0]  idx
  );
    logic [FULL_W-1:0] sh;
    int unsigned       pos;
    pos = (int'(idx) < FULL_BYTES) ? (FULL_BYTES - 1 - int'(idx)) : 0;
    sh  = word >> (BYTE_W * pos);
    return sh[BYTE_W-1:0];
  endfunction

  // Slot count of a read.
  function automatic logic [CNT_W-1:0] slot_total(
    input logic with_stat,
    input logic with_data,
    input logic wide
  );
    logic [CNT_W-1:0] nd;
    nd = wide ? CNT_W'(FULL_BYTES) : CNT_W'(NARROW_BYTES);
    return (with_stat ? CNT_W'(1) : CNT_W'(0)) + (with_data ? nd : CNT_W'(0));
  endfunction
endpackage

// File: rtl/rdfmt_snapshot.sv
module rdfmt_snapshot
  import rdfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              hold,
  input  logic [FULL_W-1:0] res_in,
  input  logic              oor_flag,
  input  logic              oor_high,
  input  logic              clamp_en,
  input  logic [BYTE_W-1:0] status_in,
  output logic [FULL_W-1:0] snap_word,
  output logic [BYTE_W-1:0] snap_stat
);
  logic [FULL_W-1:0] fmt_word;
  assign fmt_word = clamp_result(res_in, oor_flag, oor_high, clamp_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_word <= '0;
      snap_stat <= '0;
    end else if (take) begin
      snap_word <= fmt_word;
      snap_stat <= status_in;
    end
  end

  assert_snap_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(snap_word) && $stable(snap_stat)));
  assert_clamp_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && clamp_en && oor_flag && oor_high) |=> (snap_word == {FULL_W{1'b1}}));
  assert_clamp_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && clamp_en && oor_flag && !oor_high) |=> (snap_word == {FULL_W{1'b0}}));
  assert_passthru_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !clamp_en) |=> (snap_word == $past(res_in)));
endmodule

// File: rtl/rdfmt_sequencer.sv
module rdfmt_sequencer
  import rdfmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_start,
  input  logic             rd_sel,
  input  logic             dump_en,
  input  logic             cont_rd,
  input  logic             wide_sel,
  input  logic             byte_done,
  output logic             accept,
  output logic             busy,
  output logic             load,
  output logic             last,
  output logic             stat_slot,
  output logic [CNT_W-1:0] data_idx
);
  logic             chain;
  logic             want_stat, want_data;
  logic [CNT_W-1:0] pos, total;
  logic             has_stat;
  logic             advance, finish;

  assign chain     = dump_en | cont_rd;
  assign want_stat = chain | ~rd_sel;
  assign want_data = chain | rd_sel;
  assign accept    = rd_start & ~busy;
  assign last      = busy & (pos == total - CNT_W'(1));
  assign advance   = busy & byte_done & ~last;
  assign finish    = busy & byte_done & last;
  assign stat_slot = has_stat & (pos == '0);
  assign data_idx  = has_stat ? pos - CNT_W'(1) : pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      load     <= 1'b0;
      pos      <= '0;
      total    <= '0;
      has_stat <= 1'b0;
    end else begin
      load <= 1'b0;
      if (accept) begin
        busy     <= 1'b1;
        load     <= 1'b1;
        pos      <= '0;
        has_stat <= want_stat;
        total    <= slot_total(want_stat, want_data, wide_sel);
      end else if (advance) begin
        pos  <= pos + CNT_W'(1);
        load <= 1'b1;
      end else if (finish) begin
        busy <= 1'b0;
        pos  <= '0;
      end
    end
  end

  assert_load_in_xfer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> busy);
  assert_pos_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pos < total));
  assert_finish_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (!busy && !load));
  assert_no_load_wo_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !byte_done) |=> !load);
endmodule

// File: rtl/rdfmt_top.sv
module rdfmt_top
  import rdfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FULL_W-1:0] res_in,
  input  logic              oor_flag,
  input  logic              oor_high,
  input  logic [BYTE_W-1:0] status_in,
  input  logic              wide_sel,
  input  logic              clamp_en,
  input  logic              dump_en,
  input  logic              cont_rd,
  input  logic              rd_start,
  input  logic              rd_sel,
  input  logic              byte_done,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_load,
  output logic              xfer_busy,
  output logic              xfer_last
);
  logic              accept, busy, stat_slot;
  logic [CNT_W-1:0]  data_idx;
  logic [FULL_W-1:0] snap_word;
  logic [BYTE_W-1:0] snap_stat;

  rdfmt_sequencer seq_i (
    .clk(clk), .rst_n(rst_n), .rd_start(rd_start), .rd_sel(rd_sel),
    .dump_en(dump_en), .cont_rd(cont_rd), .wide_sel(wide_sel),
    .byte_done(byte_done), .accept(accept), .busy(busy), .load(byte_load),
    .last(xfer_last), .stat_slot(stat_slot), .data_idx(data_idx)
  );

  rdfmt_snapshot snap_i (
    .clk(clk), .rst_n(rst_n), .take(accept), .hold(busy), .res_in(res_in),
    .oor_flag(oor_flag), .oor_high(oor_high), .clamp_en(clamp_en),
    .status_in(status_in), .snap_word(snap_word), .snap_stat(snap_stat)
  );

  assign xfer_busy = busy;

  always_comb begin
    if (!busy)          byte_out = '0;
    else if (stat_slot) byte_out = snap_stat;
    else                byte_out = data_byte(snap_word, data_idx);
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_busy |-> (byte_out == '0 && !byte_load && !xfer_last));
endmodule

// File: tb/rdfmt_top_tb_top.sv
`timescale 1ns/1ps
module rdfmt_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] res_in = '0;
  logic        oor_flag = 1'b0, oor_high = 1'b0;
  logic [7:0]  status_in = '0;
  logic        wide_sel = 1'b0, clamp_en = 1'b0, dump_en = 1'b0, cont_rd = 1'b0;
  logic        rd_start = 1'b0, rd_sel = 1'b0, byte_done = 1'b0;
  logic [7:0]  byte_out;
  logic        byte_load, xfer_busy, xfer_last;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rdfmt_top dut_i (
    .clk(clk), .rst_n(rst_n), .res_in(res_in), .oor_flag(oor_flag),
    .oor_high(oor_high), .status_in(status_in), .wide_sel(wide_sel),
    .clamp_en(clamp_en), .dump_en(dump_en), .cont_rd(cont_rd),
    .rd_start(rd_start), .rd_sel(rd_sel), .byte_done(byte_done),
    .byte_out(byte_out), .byte_load(byte_load), .xfer_busy(xfer_busy),
    .xfer_last(xfer_last)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One read; expected stream computed from the requirements.
  task automatic run_read(input logic sel, input string tag);
    logic [23:0] word;
    logic [7:0]  exp_b [4];
    logic        ws, wd;
    int          n, got, cyc;
    word = (clamp_en && oor_flag) ? (oor_high ? 24'hFFFFFF : 24'h000000) : res_in; // R4 R5
    ws = dump_en | cont_rd | ~sel;   // R6 R7 R8
    wd = dump_en | cont_rd | sel;
    n = 0;
    if (ws) begin exp_b[n] = status_in; n++; end
    if (wd) begin
      exp_b[n] = word[23:16]; n++;   // R2 R3
      exp_b[n] = word[15:8];  n++;
      if (wide_sel) begin exp_b[n] = word[7:0]; n++; end
    end
    @(negedge clk); rd_start = 1'b1; rd_sel = sel;
    @(negedge clk); rd_start = 1'b0;
    got = 0; cyc = 0;
    while (xfer_busy && cyc < 40) begin
      cyc++;
      if (byte_load) begin
        if (got < 4) check({tag, " byte"}, 32'(byte_out), 32'(exp_b[got]));
        check({tag, " last R10"}, 32'(xfer_last), 32'(got == n - 1));
        got++;
        res_in = ~res_in ^ 24'h5A5A5A; status_in = ~status_in;   // R9
        oor_flag = ~oor_flag; clamp_en = ~clamp_en; wide_sel = ~wide_sel;
        rd_start = 1'b1;                                          // R10 stray start
        @(negedge clk); rd_start = 1'b0;
        check({tag, " no load before done R10"}, 32'(byte_load), 32'd0);
        byte_done = 1'b1;
        @(negedge clk); byte_done = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    check({tag, " byte count R9 R10"}, 32'(got), 32'(n));
    check({tag, " idle R1"}, {23'd0, xfer_busy, byte_load, byte_out}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("reset R1", {22'd0, xfer_busy, byte_load, xfer_last, byte_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("post reset R1", {22'd0, xfer_busy, byte_load, xfer_last, byte_out}, 32'd0);
    for (int k = 0; k < 3; k++) begin
      for (int cfg = 0; cfg < 32; cfg++) begin
        for (int oc = 0; oc < 3; oc++) begin
          wide_sel  = cfg[0];
          dump_en   = cfg[1];
          cont_rd   = cfg[2];
          clamp_en  = cfg[4];
          oor_flag  = (oc != 0);
          oor_high  = (oc == 1);
          res_in    = 24'(k * 24'h35A7C3 + 24'h81234 + cfg * 24'h10101);
          status_in = 8'(8'hC3 ^ cfg ^ (oc << 5));
          run_read(cfg[3], $sformatf("k%0d cfg%0d oc%0d R2 R3 R4 R5 R6 R7 R8", k, cfg, oc));
        end
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule